// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

This block decides whether an incoming Ethernet frame should be kept, looking only at its 48-bit destination address. Software programs a station address, a 64-entry multicast hash table and four accept-mode enables through a simple word-wide register bus, and can read every one of them back. The receive path hands the block the destination address one byte per cycle. A start strobe marks the first byte, and a valid qualifier marks each byte, so idle cycles between bytes are allowed.

While the bytes stream in, the block runs a CRC-32 over them one bit at a time. The top six bits of the result select one entry of the hash table. After the sixth byte the block registers a verdict: accept or reject, plus three class flags (broadcast, station match, multicast) and the hash index it used. The verdict holds until the next start strobe, so the frame logic downstream can sample it at any later point.

Top module: `rx_addr_filter`

## Requirements
- R1: The register bus decodes byte offsets. Offset 0x00 holds station bytes 0..3, with byte 0 in bits 7:0. Offset 0x04 holds station bytes 4..5 in bits 15:0, and its bits 31:16 read as zero. Offset 0x08 holds hash bits 31:0, offset 0x0C holds hash bits 63:32, and offset 0x10 holds the mode in bits 3:0. Unmapped offsets read zero. Reset clears every register to zero. Reads are combinational from `bus_addr`, and a write takes effect at the clock edge where `bus_wr` is high.
- R2: `dec_hash_idx` equals bits 31:26 of a CRC-32 over the six destination bytes in arrival order. The CRC uses polynomial 0x04C11DB7, is preset to all ones, takes each byte least significant bit first, and is not inverted. The index selects hash bit `idx`, where bits 0..31 are the word at 0x08.
- R3: An all-ones destination sets `dec_bcast` and clears `dec_mcast`. It is never accepted through the hash.
- R4: `dec_mcast` is set when bit 0 of the first address byte is 1 and the address is not all ones.
- R5: `dec_phys` is set when all six destination bytes equal the programmed station address.
- R6: `dec_accept` is computed as follows. Mode bit 0 accepts everything. Mode bit 1 accepts a station match. Mode bit 2 accepts a multicast frame whose hash bit is set. Mode bit 3 accepts broadcast. The result is the OR of these terms.
- R7: A byte counts only in a cycle where `da_valid` is high, and idle cycles between bytes are allowed. `dec_valid` rises at the clock edge that samples the sixth byte. It is low at every edge before that.
- R8: Once `dec_valid` is high, the verdict outputs hold their values until the next start. Any further bytes and any register writes leave them unchanged.
- R9: A byte with `da_start` and `da_valid` both high restarts address collection, and `dec_valid` goes low at that edge. `da_start` without `da_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| da_start | input | 1 | Marks the first destination byte |
| da_valid | input | 1 | Destination byte qualifier |
| da_byte | input | 8 | Destination address byte |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame accepted |
| dec_bcast | output | 1 | Broadcast class |
| dec_phys | output | 1 | Station address match |
| dec_mcast | output | 1 | Multicast class |
| dec_hash_idx | output | 6 | Hash index used for the frame |

## Verification
The bench compares the hash index of every frame with a separate bit-serial CRC model. Such a check exposes a bad preset, a wrong bit order within a byte, or an inverted result as a wrong index on nearly every address. Directed frames put the broadcast address against a hash table that is entirely ones with broadcast disabled. A design that lets broadcast fall through to the hash would accept that frame. Another directed frame differs from the station address in a single bit of the last byte, which catches a comparison that ignores part of the address.

Some frames carry idle gaps between bytes, and others are followed by extra bytes and register writes. A counter that advances without `da_valid`, or a verdict that is recomputed from live registers, would then show the verdict too early or let it drift.

// File: rtl/filt_pkg.sv
package filt_pkg;
    localparam int DA_BYTES = 6;
    localparam int DA_W     = 8 * DA_BYTES;
    localparam int HASH_W   = 6;
    localparam int HASH_N   = 1 << HASH_W;
    localparam int CRC_W    = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam int REG_AW   = 5;
    localparam int MODE_W   = 4;

    localparam logic [REG_AW-1:0] OFS_STA_LO  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_STA_HI  = 5'h04;
    localparam logic [REG_AW-1:0] OFS_HASH_LO = 5'h08;
    localparam logic [REG_AW-1:0] OFS_HASH_HI = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_MODE    = 5'h10;

    localparam int MODE_ALL   = 0;
    localparam int MODE_PHYS  = 1;
    localparam int MODE_MCAST = 2;
    localparam int MODE_BCAST = 3;

    typedef struct packed {
        logic [DA_W-1:0]   sta;
        logic [HASH_N-1:0] hash;
        logic [MODE_W-1:0] mode;
    } filt_regs_t;

    // One byte through the CRC shift register, LSB of the byte first.
    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                       input logic [7:0] b);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int k = 0; k < 8; k++) begin
            fb = c[CRC_W-1] ^ b[k];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction
endpackage

// File: rtl/filt_regs.sv
module filt_regs
    import filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output filt_regs_t        regs
);
    filt_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_STA_LO:  regs_d.sta[31:0]      = bus_wdata;
                OFS_STA_HI:  regs_d.sta[DA_W-1:32] = bus_wdata[DA_W-33:0];
                OFS_HASH_LO: regs_d.hash[31:0]     = bus_wdata;
                OFS_HASH_HI: regs_d.hash[63:32]    = bus_wdata;
                OFS_MODE:    regs_d.mode           = bus_wdata[MODE_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_STA_LO:  bus_rdata = regs_q.sta[31:0];
            OFS_STA_HI:  bus_rdata[DA_W-33:0] = regs_q.sta[DA_W-1:32];
            OFS_HASH_LO: bus_rdata = regs_q.hash[31:0];
            OFS_HASH_HI: bus_rdata = regs_q.hash[63:32];
            OFS_MODE:    bus_rdata[MODE_W-1:0] = regs_q.mode;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_hash_lo_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_HASH_LO) |=> (regs_q.hash[31:0] == $past(bus_wdata)));

    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(regs_q.mode));
endmodule

// File: rtl/addr_crc_hash.sv
module addr_crc_hash
    import filt_pkg::*;
#(
    parameter int NB = DA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_start,
    input  logic              da_valid,
    input  logic [7:0]        da_byte,
    output logic              fin,
    output logic              restart,
    output logic [8*NB-1:0]   addr_full,
    output logic [HASH_W-1:0] idx_full
);
    localparam int CNT_W = $clog2(NB + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic [8*NB-1:0]  addr;
    } col_t;

    col_t col_d, col_q;
    logic take;
    logic [CRC_W-1:0] base_crc;
    logic [CNT_W-1:0] base_cnt;
    logic [8*NB-1:0]  base_addr;

    always_comb begin
        take      = da_valid && (da_start || col_q.active);
        base_crc  = da_start ? '1 : col_q.crc;
        base_cnt  = da_start ? '0 : col_q.cnt;
        base_addr = da_start ? '0 : col_q.addr;
        col_d     = col_q;
        if (take) begin
            col_d.crc  = crc_step_byte(base_crc, da_byte);
            col_d.addr = base_addr;
            col_d.addr[8*base_cnt +: 8] = da_byte;
            col_d.cnt  = base_cnt + 1'b1;
            col_d.active = (col_d.cnt != CNT_W'(NB));
        end
        fin       = take && (col_d.cnt == CNT_W'(NB));
        restart   = da_valid && da_start;
        addr_full = col_d.addr;
        idx_full  = col_d.crc[CRC_W-1 -: HASH_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    assert_gap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> ($stable(col_q.crc) && $stable(col_q.cnt)));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_q.active |-> (col_q.cnt < CNT_W'(NB)));
endmodule

// File: rtl/addr_match.sv
module addr_match
    import filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin,
    input  logic              restart,
    input  logic [DA_W-1:0]   addr,
    input  logic [HASH_W-1:0] idx,
    input  filt_regs_t        regs,
    output logic              dv,
    output logic              acc,
    output logic              bc,
    output logic              ph,
    output logic              mc,
    output logic [HASH_W-1:0] hidx
);
    typedef struct packed {
        logic              dv;
        logic              acc;
        logic              bc;
        logic              ph;
        logic              mc;
        logic [HASH_W-1:0] idx;
    } verdict_t;

    verdict_t v_d, v_q;
    logic is_bc, is_mc, is_ph, hit;

    always_comb begin
        is_bc = &addr;
        is_mc = addr[0] && !is_bc;
        is_ph = (addr == regs.sta);
        hit   = regs.hash[idx];
        v_d   = v_q;
        if (fin) begin
            v_d.dv  = 1'b1;
            v_d.bc  = is_bc;
            v_d.mc  = is_mc;
            v_d.ph  = is_ph;
            v_d.idx = idx;
            v_d.acc = regs.mode[MODE_ALL]
                   || (regs.mode[MODE_PHYS]  && is_ph)
                   || (regs.mode[MODE_MCAST] && is_mc && hit)
                   || (regs.mode[MODE_BCAST] && is_bc);
        end else if (restart) begin
            v_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign dv   = v_q.dv;
    assign acc  = v_q.acc;
    assign bc   = v_q.bc;
    assign ph   = v_q.ph;
    assign mc   = v_q.mc;
    assign hidx = v_q.idx;

    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q.dv && !restart && !fin) |=> (v_q.dv && $stable(v_q.acc) && $stable(v_q.idx)
                                          && $stable(v_q.ph) && $stable(v_q.mc)));

    assert_bcast_not_mcast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_q.bc |-> !v_q.mc);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              da_start,
    input  logic              da_valid,
    input  logic [7:0]        da_byte,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              dec_bcast,
    output logic              dec_phys,
    output logic              dec_mcast,
    output logic [HASH_W-1:0] dec_hash_idx
);
    filt_regs_t        regs;
    logic              fin, restart;
    logic [DA_W-1:0]   addr_full;
    logic [HASH_W-1:0] idx_full;

    filt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .regs(regs)
    );

    addr_crc_hash #(.NB(DA_BYTES)) u_crc (
        .clk(clk), .rst_n(rst_n), .da_start(da_start), .da_valid(da_valid),
        .da_byte(da_byte), .fin(fin), .restart(restart),
        .addr_full(addr_full), .idx_full(idx_full)
    );

    addr_match u_match (
        .clk(clk), .rst_n(rst_n), .fin(fin), .restart(restart),
        .addr(addr_full), .idx(idx_full), .regs(regs),
        .dv(dec_valid), .acc(dec_accept), .bc(dec_bcast), .ph(dec_phys),
        .mc(dec_mcast), .hidx(dec_hash_idx)
    );

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (da_start && da_valid) |=> !dec_valid);

    assert_rise_on_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(da_valid));
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic da_start = 1'b0, da_valid = 1'b0;
    logic [7:0] da_byte = '0;
    logic dec_valid, dec_accept, dec_bcast, dec_phys, dec_mcast;
    logic [5:0] dec_hash_idx;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [47:0] b_sta = '0;
    logic [63:0] b_hash = '0;
    logic [3:0]  b_mode = '0;

    always #4 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .da_start(da_start),
        .da_valid(da_valid), .da_byte(da_byte), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_bcast(dec_bcast), .dec_phys(dec_phys),
        .dec_mcast(dec_mcast), .dec_hash_idx(dec_hash_idx)
    );

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic top = c[31];
            c = c << 1;
            if (top ^ a[i]) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] a);
        logic bc = (a == 48'hFFFF_FFFF_FFFF);
        logic mc = a[0] && !bc;
        logic ph = (a == b_sta);
        return b_mode[0] || (b_mode[1] && ph) || (b_mode[2] && mc && b_hash[ref_idx(a)])
               || (b_mode[3] && bc);
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            5'h00: b_sta[31:0]  = d;
            5'h04: b_sta[47:32] = d[15:0];
            5'h08: b_hash[31:0] = d;
            5'h0C: b_hash[63:32] = d;
            5'h10: b_mode = d[3:0];
            default: ;
        endcase
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, "R1 readback", bus_rdata, exp);
    endtask

    task automatic send(input logic [47:0] a, input bit gaps);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 1) check(dec_valid == 1'b0, "R9/R7 valid low mid-address", dec_valid, 0);
            da_start = (i == 0); da_valid = 1'b1; da_byte = a[8*i +: 8];
            if (gaps && i < 5) begin
                @(negedge clk);
                da_start = 1'b0; da_valid = 1'b0; da_byte = 8'hA5;
            end
        end
        @(negedge clk);
        da_start = 1'b0; da_valid = 1'b0;
    endtask

    task automatic verify(input logic [47:0] a);
        logic bc = (a == 48'hFFFF_FFFF_FFFF);
        check(dec_valid == 1'b1, "R7 valid after sixth byte", dec_valid, 1);
        check(dec_hash_idx == ref_idx(a), "R2 hash index", dec_hash_idx, ref_idx(a));
        check(dec_bcast == bc, "R3 broadcast flag", dec_bcast, bc);
        check(dec_mcast == (a[0] && !bc), "R4 multicast flag", dec_mcast, a[0] && !bc);
        check(dec_phys == (a == b_sta), "R5 station match", dec_phys, a == b_sta);
        check(dec_accept == ref_accept(a), "R6 accept", dec_accept, ref_accept(a));
    endtask

    task automatic frame(input logic [47:0] a, input bit gaps);
        send(a, gaps);
        verify(a);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [47:0] a, sv_a;
        logic sv_acc;
        logic [5:0] sv_idx;
        seed = $urandom(32'h5EED_0011);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, R7 no verdict after reset
        check(dec_valid == 1'b0, "R7 reset valid", dec_valid, 0);
        rd_check(5'h00, 0); rd_check(5'h04, 0); rd_check(5'h08, 0);
        rd_check(5'h0C, 0); rd_check(5'h10, 0);

        // R1 register readback
        wr(5'h04, 32'hFFFF_FFFF);
        rd_check(5'h04, 32'h0000_FFFF);
        wr(5'h00, 32'h4433_2210);
        wr(5'h04, 32'h0000_6655);
        wr(5'h08, 32'h1234_5678);
        wr(5'h0C, 32'h9ABC_DEF0);
        wr(5'h10, 32'hFFFF_FFF5);
        rd_check(5'h00, 32'h4433_2210); rd_check(5'h04, 32'h0000_6655);
        rd_check(5'h08, 32'h1234_5678); rd_check(5'h0C, 32'h9ABC_DEF0);
        rd_check(5'h10, 32'h5); rd_check(5'h14, 0);

        // R3: broadcast with hash all ones, multicast on, broadcast off -> reject
        wr(5'h08, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF); wr(5'h10, 32'h4);
        frame(48'hFFFF_FFFF_FFFF, 0);
        check(dec_accept == 1'b0, "R3 broadcast not via hash", dec_accept, 0);
        wr(5'h10, 32'h8);
        frame(48'hFFFF_FFFF_FFFF, 0);
        check(dec_accept == 1'b1, "R6 broadcast accepted", dec_accept, 1);

        // R4/R6: multicast hit and miss
        wr(5'h08, 0); wr(5'h0C, 0); wr(5'h10, 32'h4);
        a = 48'h0000_5E00_0001 | 48'h1;
        frame(a, 0);
        check(dec_accept == 1'b0, "R6 multicast hash miss", dec_accept, 0);
        if (ref_idx(a) < 32) wr(5'h08, 32'h1 << ref_idx(a));
        else                 wr(5'h0C, 32'h1 << (ref_idx(a) - 32));
        frame(a, 1);
        check(dec_accept == 1'b1, "R6 multicast hash hit", dec_accept, 1);

        // R5: station match and one-bit miss in the last byte
        wr(5'h10, 32'h2);
        frame(48'h6655_4433_2210, 0);
        check(dec_phys == 1'b1, "R5 exact station", dec_phys, 1);
        frame(48'h6755_4433_2210, 0);
        check(dec_accept == 1'b0, "R5 one bit off", dec_accept, 0);

        // R6 accept-all
        wr(5'h10, 32'h1);
        frame(48'h0102_0304_0500, 0);

        // R8: extra bytes and register writes do not disturb the verdict
        wr(5'h10, 32'h0);
        sv_a = 48'h6655_4433_2210;
        send(sv_a, 0);
        sv_acc = dec_accept; sv_idx = dec_hash_idx;
        @(negedge clk); da_valid = 1'b1; da_byte = 8'h77;
        @(negedge clk); da_byte = 8'h11;
        @(negedge clk); da_valid = 1'b0;
        wr(5'h10, 32'hF);
        wr(5'h00, 32'h0);
        check(dec_valid == 1'b1 && dec_accept == sv_acc, "R8 verdict held", dec_accept, sv_acc);
        check(dec_hash_idx == sv_idx, "R8 index held", dec_hash_idx, sv_idx);
        // R9: start without valid has no effect
        @(negedge clk); da_start = 1'b1; da_valid = 1'b0;
        @(negedge clk); da_start = 1'b0;
        check(dec_valid == 1'b1, "R9 start without valid ignored", dec_valid, 1);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r = $urandom;
            if (r[3:0] == 0) wr(5'h10, $urandom);
            if (r[7:4] == 0) begin wr(5'h08, $urandom); wr(5'h0C, $urandom); end
            case (r[10:8])
                3'd0: a = 48'hFFFF_FFFF_FFFF;
                3'd1, 3'd2: a = b_sta;
                3'd3: a = {$urandom, $urandom} | 48'h1;
                default: a = {$urandom, $urandom};
            endcase
            if (r[11]) begin wr(5'h00, $urandom); wr(5'h04, $urandom); end
            frame(a, r[12]);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule